// File: doc/BRIEF.md
# Two-Bit Hardware Cursor Overlay

This block sits in a display pipeline between the framebuffer scan-out and the video encoder. It lays a 64x64 pointer image over the pixel stream. Each incoming pixel beat carries its screen coordinates, a start-of-frame flag and a colour. When the beat falls inside the cursor window, the overlay looks up a 2-bit code in a small internal image memory. The code picks one of two programmable cursor colours, lets the background through, or outputs the bitwise complement of the background.

The host loads the image memory through a byte write port. It programs the cursor through five plain registers: control, packed position, image base, colour 0 and colour 1. The pixel path is valid/ready on both sides. A beat is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` equals `!out_valid || out_ready`, so a stalled output freezes the whole pipeline and no beat is dropped or repeated. Beats move two register stages from input to output.

Top module: `cursor_overlay`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. Control, position, base and colour registers reset to 0, which leaves the cursor disabled.
- R2: When the cursor is not shown, every output pixel equals its input pixel. With `out_ready` held high, a beat accepted at edge k appears on `out_pix` with `out_valid` high right after edge k+1.
- R3: With active position (X, Y), a pixel at (hx, hy) is covered only when X <= hx < X+64 and Y <= hy < Y+64. Pixels outside that window pass through unchanged.
- R4: Inside the window, code 2'b00 outputs the colour 0 register and code 2'b01 outputs the colour 1 register.
- R5: Inside the window, code 2'b10 passes the input pixel through, and code 2'b11 outputs its bitwise complement.
- R6: Image byte address = base + (hy-Y)*16 + ((hx-X)>>2), taken modulo the memory size. Column (hx-X)%4 = 0,1,2,3 takes the code from bits 7:6, 5:4, 3:2 and 1:0 of that byte.
- R7: Position register (address 1) holds X in bits 15:0 and Y in bits 31:16. A write is staged and becomes active when the next beat with `in_sof`=1 is accepted, and that beat already uses it. A write landing on the same edge as that sof beat is held over to the following frame.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_pix` stay unchanged. Every accepted beat leaves exactly once, in order.
- R9: Control register (address 0): bit 0 enables the cursor, and bits 2:1 select the mode. The cursor is shown only when bit 0 is 1 and bits 2:1 are 2'b00; any other mode value passes pixels through.
- R10: Base register (address 2) selects where the 1024-byte image starts in the image memory.
- R11: An image byte of 8'hAA makes its four pixels pass the background through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 position, 2 base, 3 colour 0, 4 colour 1 |
| reg_wdata | input | 32 | Register write data |
| img_we | input | 1 | Image memory byte write strobe |
| img_addr | input | AW (11) | Image memory byte address |
| img_wdata | input | 8 | Image byte (four 2-bit codes) |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_sof | input | 1 | Beat is the first pixel of a frame |
| in_x | input | 16 | Pixel column |
| in_y | input | 16 | Pixel row |
| in_pix | input | PIX_W (24) | Background pixel |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can take the output beat |
| out_pix | output | PIX_W (24) | Composited pixel |

## Verification
A position register write and the acceptance of a start-of-frame beat can fall on the same clock edge. The bench provokes this by raising `reg_we` with a new position in the very cycle a sof beat is handed over with `out_ready` held high. The frame that begins there must still draw at the previously staged position. The new one must appear only at the following sof beat. The scoreboard judges this because its model stages positions the same way and predicts hits at the old and new coordinates on both frames.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

  typedef enum logic [1:0] {
    CODE_COL0   = 2'b00,
    CODE_COL1   = 2'b01,
    CODE_CLEAR  = 2'b10,
    CODE_INVERT = 2'b11
  } cur_code_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_POS  = 3'd1;
  localparam logic [2:0] RA_BASE = 3'd2;
  localparam logic [2:0] RA_COL0 = 3'd3;
  localparam logic [2:0] RA_COL1 = 3'd4;

  typedef struct packed {
    logic [15:0] y;
    logic [15:0] x;
  } cur_pos_t;

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_ovl_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int AW    = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             frame_adv,
  output logic             show,
  output cur_pos_t         pos_eff,
  output logic [AW-1:0]    base,
  output logic [PIX_W-1:0] col0,
  output logic [PIX_W-1:0] col1
);

  logic [2:0] ctrl;
  cur_pos_t   pos_pend;
  cur_pos_t   pos_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      pos_pend <= '0;
      pos_act  <= '0;
      base     <= '0;
      col0     <= '0;
      col1     <= '0;
    end else begin
      if (frame_adv) pos_act <= pos_pend;
      if (reg_we) begin
        unique case (reg_addr)
          RA_CTRL: ctrl     <= reg_wdata[2:0];
          RA_POS:  pos_pend <= reg_wdata;
          RA_BASE: base     <= reg_wdata[AW-1:0];
          RA_COL0: col0     <= reg_wdata[PIX_W-1:0];
          RA_COL1: col1     <= reg_wdata[PIX_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // A sof beat already sees the staged position.
  assign pos_eff = frame_adv ? pos_pend : pos_act;
  assign show    = ctrl[0] && (ctrl[2:1] == 2'b00);

  a_r7_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_adv |=> pos_act == $past(pos_pend));

  a_r7_hold_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_adv |=> $stable(pos_act));

  a_r9_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_CTRL) |=> ctrl == $past(reg_wdata[2:0]));

endmodule

// File: rtl/cursor_window.sv
module cursor_window
  import cursor_ovl_pkg::*;
#(
  parameter int DIM = 64,
  parameter int AW  = 11
) (
  input  logic [15:0]   px,
  input  logic [15:0]   py,
  input  cur_pos_t      pos,
  input  logic [AW-1:0] base,
  output logic          hit,
  output logic [AW-1:0] addr,
  output logic [1:0]    sel
);

  localparam int IDX_W = $clog2(DIM);
  localparam int OFS_W = 2 * IDX_W - 2;

  logic [15:0]      dx, dy;
  logic [OFS_W-1:0] offset;
  logic             in_x, in_y;

  assign dx   = px - pos.x;
  assign dy   = py - pos.y;
  assign in_x = (px >= pos.x) && (dx < 16'(DIM));
  assign in_y = (py >= pos.y) && (dy < 16'(DIM));
  assign hit  = in_x && in_y;

  // Row stride is DIM/4 bytes, a power of two: concatenation forms the offset.
  assign offset = {dy[IDX_W-1:0], dx[IDX_W-1:2]};
  assign addr   = base + AW'(offset);
  assign sel    = dx[1:0];

endmodule

// File: rtl/cursor_image_ram.sv
module cursor_image_ram #(
  parameter int MEM_BYTES = 2048,
  parameter int AW        = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/cursor_decode.sv
module cursor_decode
  import cursor_ovl_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic [7:0]       img_byte,
  input  logic [1:0]       sel,
  input  logic             covered,
  input  logic [PIX_W-1:0] bg,
  input  logic [PIX_W-1:0] col0,
  input  logic [PIX_W-1:0] col1,
  output logic [PIX_W-1:0] pix
);

  cur_code_e code;

  // Leftmost pixel of a byte lives in the top two bits.
  always_comb begin
    unique case (sel)
      2'd0: code = cur_code_e'(img_byte[7:6]);
      2'd1: code = cur_code_e'(img_byte[5:4]);
      2'd2: code = cur_code_e'(img_byte[3:2]);
      default: code = cur_code_e'(img_byte[1:0]);
    endcase
  end

  always_comb begin
    if (!covered) pix = bg;
    else begin
      unique case (code)
        CODE_COL0:   pix = col0;
        CODE_COL1:   pix = col1;
        CODE_CLEAR:  pix = bg;
        default:     pix = ~bg;
      endcase
    end
  end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_ovl_pkg::*;
#(
  parameter int PIX_W     = 24,
  parameter int DIM       = 64,
  parameter int MEM_BYTES = 2048,
  localparam int AW       = $clog2(MEM_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             img_we,
  input  logic [AW-1:0]    img_addr,
  input  logic [7:0]       img_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sof,
  input  logic [15:0]      in_x,
  input  logic [15:0]      in_y,
  input  logic [PIX_W-1:0] in_pix,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_pix
);

  logic             advance, accept;
  logic             show;
  cur_pos_t         pos_eff;
  logic [AW-1:0]    base;
  logic [PIX_W-1:0] col0, col1;
  logic             hit;
  logic [AW-1:0]    rd_addr;
  logic [1:0]       sel;
  logic [7:0]       img_byte;

  logic             s1_v, s1_hit;
  logic [1:0]       s1_sel;
  logic [PIX_W-1:0] s1_pix;
  logic [PIX_W-1:0] dec_pix;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && advance;

  cursor_regs #(.PIX_W(PIX_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .frame_adv(accept && in_sof),
    .show(show), .pos_eff(pos_eff), .base(base),
    .col0(col0), .col1(col1)
  );

  cursor_window #(.DIM(DIM), .AW(AW)) u_window (
    .px(in_x), .py(in_y), .pos(pos_eff), .base(base),
    .hit(hit), .addr(rd_addr), .sel(sel)
  );

  cursor_image_ram #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_ram (
    .clk(clk), .we(img_we), .waddr(img_addr), .wdata(img_wdata),
    .re(accept), .raddr(rd_addr), .rdata(img_byte)
  );

  cursor_decode #(.PIX_W(PIX_W)) u_decode (
    .img_byte(img_byte), .sel(s1_sel), .covered(s1_hit),
    .bg(s1_pix), .col0(col0), .col1(col1), .pix(dec_pix)
  );

  // Stage 1: accepted beat plus memory read; stage 2: composited output.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_hit    <= 1'b0;
      s1_sel    <= '0;
      s1_pix    <= '0;
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (advance) begin
      s1_v      <= in_valid;
      s1_hit    <= hit && show;
      s1_sel    <= sel;
      s1_pix    <= in_pix;
      out_valid <= s1_v;
      out_pix   <= dec_pix;
    end
  end

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  a_r8_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  a_r2_miss_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && s1_v && !s1_hit) |=> out_pix == $past(s1_pix));

endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;

  localparam int PIX_W = 24;
  localparam int MEMB  = 2048;
  localparam int AW    = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0;
  logic [2:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0;
  logic             img_we = 1'b0;
  logic [AW-1:0]    img_addr = '0;
  logic [7:0]       img_wdata = '0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_sof = 1'b0;
  logic [15:0]      in_x = '0;
  logic [15:0]      in_y = '0;
  logic [PIX_W-1:0] in_pix = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [PIX_W-1:0] out_pix;

  int checks = 0;
  int failures = 0;
  bit rand_ready = 1'b0;
  bit done = 1'b0;

  // Model state
  logic [7:0]       mirror [MEMB];
  logic [2:0]       m_ctrl = '0;
  int               m_px = 0, m_py = 0, m_ax = 0, m_ay = 0, m_base = 0;
  logic [PIX_W-1:0] m_c0 = '0, m_c1 = '0;

  logic [PIX_W-1:0] exp_q [$];
  string            tag_q [$];

  bit               prev_stall = 1'b0;
  logic [PIX_W-1:0] prev_pix = '0;

  always #10 clk = ~clk;

  cursor_overlay u_cursor_overlay (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .img_we(img_we), .img_addr(img_addr), .img_wdata(img_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_x(in_x), .in_y(in_y), .in_pix(in_pix),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PIX_W-1:0] model(input int x, input int y, input logic [PIX_W-1:0] p,
                                             output string kind);
    int dx, dy, idx;
    logic [7:0] b;
    logic [1:0] code;
    dx = x - m_ax;
    dy = y - m_ay;
    if (!(m_ctrl == 3'b001) || dx < 0 || dx > 63 || dy < 0 || dy > 63) begin
      kind = "R3";
      return p;
    end
    idx  = (m_base + dy * 16 + dx / 4) % MEMB;
    b    = mirror[idx];
    code = 2'((b >> (6 - 2 * (dx % 4))) & 8'h3);
    case (code)
      2'b00: begin kind = "R4"; return m_c0; end
      2'b01: begin kind = "R4"; return m_c1; end
      2'b10: begin kind = "R5"; return p; end
      default: begin kind = "R5"; return ~p; end
    endcase
  endfunction

  // Monitor: a handshake seen at a negedge completes at the next posedge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(out_valid && out_pix == prev_pix, "R8 stall hold", 32'(out_pix), 32'(prev_pix));
      prev_stall = out_valid && !out_ready;
      prev_pix   = out_pix;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R8 extra beat", 32'(out_pix), 32'h0);
        else begin
          logic [PIX_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_pix == e, t, 32'(out_pix), 32'(e));
        end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = rand_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
    case (a)
      3'd0: m_ctrl = d[2:0];
      3'd1: begin m_px = int'(d[15:0]); m_py = int'(d[31:16]); end
      3'd2: m_base = int'(d[AW-1:0]);
      3'd3: m_c0 = d[PIX_W-1:0];
      3'd4: m_c1 = d[PIX_W-1:0];
      default: ;
    endcase
  endtask

  task automatic img_write(input int a, input logic [7:0] d);
    img_we = 1'b1; img_addr = AW'(a); img_wdata = d;
    @(posedge clk); #1;
    img_we = 1'b0;
    mirror[a] = d;
  endtask

  // Send one beat; optionally write the position register on the accept edge.
  task automatic send(input bit sof, input int x, input int y, input logic [PIX_W-1:0] p,
                      input string grp, input bit pos_wr = 1'b0, input logic [31:0] pos_val = '0);
    string kind;
    logic [PIX_W-1:0] e;
    in_valid = 1'b1; in_sof = sof; in_x = 16'(x); in_y = 16'(y); in_pix = p;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    if (pos_wr) begin
      reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = pos_val;
    end
    if (sof) begin m_ax = m_px; m_ay = m_py; end
    e = model(x, y, p, kind);
    exp_q.push_back(e);
    tag_q.push_back({grp, "/", kind});
    @(posedge clk); #1;
    in_valid = 1'b0; in_sof = 1'b0; reg_we = 1'b0;
    if (pos_wr) begin m_px = int'(pos_val[15:0]); m_py = int'(pos_val[31:16]); end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    #1;
  endtask

  function automatic logic [PIX_W-1:0] bgp(input int x, input int y);
    return PIX_W'(x * 40503 + y * 977 + 12345);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'h0);
    check(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'h1);
    @(posedge clk); #1;

    for (int a = 0; a < MEMB; a++) img_write(a, 8'((a * 73 + 5) & 255));
    // R1: with reset registers nothing is drawn even at the origin
    send(1'b1, 0, 0, bgp(0, 0), "R1");
    send(1'b0, 3, 2, bgp(3, 2), "R1");

    reg_write(3'd3, 32'h00123456);
    reg_write(3'd4, 32'h00abcdef);
    reg_write(3'd1, {16'd50, 16'd100});
    send(1'b1, 0, 0, bgp(0, 0), "R7");
    // R2 disabled: window pixels pass through
    for (int x = 100; x < 110; x++) send(1'b0, x, 55, bgp(x, 55), "R2");
    drain();
    // R9 enable with mode 01: still passthrough
    reg_write(3'd0, 32'h3);
    for (int x = 100; x < 110; x++) send(1'b0, x, 56, bgp(x, 56), "R9");
    drain();
    reg_write(3'd0, 32'h1);
    send(1'b1, 0, 0, bgp(0, 0), "R9");
    // R3/R6 window edges and packing
    for (int x = 96; x < 169; x++) send(1'b0, x, 50, bgp(x, 50), "R6");
    for (int x = 98; x < 103; x++) send(1'b0, x, 49, bgp(x, 49), "R3");
    for (int x = 96; x < 169; x++) send(1'b0, x, 113, bgp(x, 113), "R6");
    for (int x = 160; x < 166; x++) send(1'b0, x, 114, bgp(x, 114), "R3");
    drain();

    // R10 image base
    reg_write(3'd2, 32'd1024);
    for (int x = 99; x < 166; x++) send(1'b0, x, 77, bgp(x, 77), "R10");
    drain();
    // R11 transparent row
    for (int b = 0; b < 16; b++) img_write(1024 + 5 * 16 + b, 8'hAA);
    for (int x = 100; x < 164; x++) send(1'b0, x, 55, bgp(x, 55), "R11");
    drain();

    // R7: staged position waits for sof
    reg_write(3'd1, {16'd10, 16'd200});
    for (int x = 100; x < 106; x++) send(1'b0, x, 60, bgp(x, 60), "R7");
    send(1'b1, 200, 10, bgp(200, 10), "R7");
    for (int x = 198; x < 206; x++) send(1'b0, x, 11, bgp(x, 11), "R7");
    // R7: write coinciding with sof beat goes to the next frame
    send(1'b1, 0, 0, bgp(0, 0), "R7", 1'b1, {16'd300, 16'd300});
    for (int x = 198; x < 204; x++) send(1'b0, x, 12, bgp(x, 12), "R7");
    send(1'b0, 301, 301, bgp(301, 301), "R7");
    send(1'b1, 301, 301, bgp(301, 301), "R7");
    for (int x = 298; x < 306; x++) send(1'b0, x, 302, bgp(x, 302), "R7");
    drain();

    // R2 latency: accept edge k, output after edge k+1
    reg_write(3'd0, 32'h0);
    send(1'b0, 7, 7, bgp(7, 7), "R2");
    @(negedge clk);
    check(out_valid == 1'b0, "R2 latency early", 32'(out_valid), 32'h0);
    @(negedge clk);
    check(out_valid == 1'b1 && out_pix == bgp(7, 7), "R2 latency", 32'(out_pix), 32'(bgp(7, 7)));
    drain();

    // R8 back-pressure
    reg_write(3'd0, 32'h1);
    rand_ready = 1'b1;
    for (int i = 0; i < 300; i++) send(1'b0, 296 + (i % 72), 300 + (i / 72), bgp(i, 9), "R8");
    drain();
    rand_ready = 1'b0;
    repeat (4) @(posedge clk);
    check(exp_q.size() == 0 && out_valid == 1'b0, "R8 all delivered", 32'(exp_q.size()), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule